// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of a two-wire serial bus in front of a small byte-addressed memory. It watches SCL and SDA, which arrive already synchronised to the system clock. It recognises START and STOP conditions and shifts in bytes MSB first on the high phase of each SCL pulse. It answers with an open-drain pull on SDA, and that pull changes only while SCL is low. A master addresses the device with a select byte. A write carries two address bytes and then any number of data bytes. A read streams bytes from the current address for as long as the master keeps acknowledging.

Write data is collected in a 16-slot page buffer indexed by the low address bits, so a long write keeps only its most recent sixteen bytes. A STOP that closes a write containing at least one complete data byte starts a modelled programming cycle. The cycle runs for a fixed number of system clocks, and the buffered bytes are then copied into a synchronous RAM. While the cycle runs, the slave acknowledges nothing.

Top module: `twi_eeprom_slave`

## Requirements
- R1: After reset the slave does not pull SDA (`sda_pull_o` = 0).
- R2: SDA falling while SCL is high (START) abandons any partly received byte or operation, and the next eight bits are taken as a fresh select byte.
- R3: SDA rising while SCL is high (STOP) ends the operation; bytes clocked afterwards without a new START are never acknowledged.
- R4: The select byte is, MSB first, `1010`, three bits equal to `cs_strap_i[2:0]`, then the direction bit (1 = read). On any mismatch the slave leaves SDA released for that byte and every later byte until the next START.
- R5: An accepted byte is acknowledged by pulling SDA low from the SCL fall after its eighth bit until the SCL fall after the ninth pulse, covering the entire ninth high phase.
- R6: A write sends an upper address byte (its low 5 bits used) and a lower address byte, forming a 13-bit address. A later read returns the stored byte at that address and continues with the following addresses.
- R7: Write bytes land in 16 slots chosen by address bits [3:0], which advance by one per byte and wrap from 15 to 0 within the page. Past sixteen bytes, the oldest slot is overwritten.
- R8: From a qualifying STOP, for PROG_CYCLES system clocks plus one clock per slot, every byte, including the select byte, goes unacknowledged. Afterwards the buffered bytes are readable from memory.
- R9: During a read, if the master leaves the ninth bit high, the slave stops sending and keeps SDA released until the next START.
- R10: A STOP starts programming only when at least one complete data byte was received since the last START. An address-only or partial-byte write leaves the slave immediately responsive.
- R11: Each byte the master acknowledges in a read advances the 13-bit address, and the address wraps from 0x1FFF to 0x0000.
- R12: A START arriving after data bytes but before STOP discards the buffered bytes, so the following STOP programs nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised bus clock level |
| sda_i | input | 1 | Synchronised bus data level (wired-AND of all drivers) |
| cs_strap_i | input | 3 | Chip-select strap compared with the select byte |
| sda_pull_o | output | 1 | 1 = pull SDA low (open-drain enable) |

## Verification
Bus levels are registered once, so an edge on SCL or SDA is seen one system clock after it is applied. The SDA pull then changes one clock after the detected SCL fall. The bench therefore reads every slave-driven bit at least two clocks after the SCL fall that launched it, and reads each acknowledge twice: just after SCL rises and just before it falls. Commit completes PROG_CYCLES plus sixteen clocks after the STOP. Read-back checks wait beyond that, while the busy check probes the slave right after the STOP.

// File: rtl/twi_ee_pkg.sv
package twi_ee_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WDATA,
        ST_RDATA,
        ST_SKIP
    } twi_st_e;

    typedef enum logic [1:0] {
        PG_OFF,
        PG_WAIT,
        PG_COMMIT
    } prog_e;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

endpackage

// File: rtl/twi_bus_edge.sv
module twi_bus_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic scl;
        logic sda;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d.scl = scl_i;
        smp_d.sda = sda_i;
        start_o   = smp_q.scl & scl_i & smp_q.sda & ~sda_i;
        stop_o    = smp_q.scl & scl_i & ~smp_q.sda & sda_i;
        rise_o    = ~smp_q.scl & scl_i;
        fall_o    = smp_q.scl & ~scl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '{scl: 1'b1, sda: 1'b1};
        else        smp_q <= smp_d;
    end

    // R2/R3: a START and a STOP can never be reported together
    p_cond_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_o && stop_o));

endmodule

// File: rtl/twi_page_buf.sv
module twi_page_buf #(
    parameter int SLOTS = 16,
    parameter int DW    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_i,
    input  logic                     wr_i,
    input  logic [$clog2(SLOTS)-1:0] wslot_i,
    input  logic [DW-1:0]            wdata_i,
    input  logic [$clog2(SLOTS)-1:0] rslot_i,
    output logic [DW-1:0]            rdata_o,
    output logic                     rvalid_o
);
    localparam int SW = $clog2(SLOTS);

    logic [SLOTS-1:0] we_vec;
    logic [SLOTS-1:0] vld;
    logic [DW-1:0]    dat [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic          v_d, v_q;
        logic [DW-1:0] b_d, b_q;

        assign we_vec[g] = wr_i && (wslot_i == SW'(g));

        always_comb begin
            b_d = we_vec[g] ? wdata_i : b_q;
            v_d = clr_i ? 1'b0 : (we_vec[g] ? 1'b1 : v_q);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                b_q <= '0;
            end else begin
                v_q <= v_d;
                b_q <= b_d;
            end
        end

        assign vld[g] = v_q;
        assign dat[g] = b_q;
    end

    assign rdata_o  = dat[rslot_i];
    assign rvalid_o = vld[rslot_i];

    // R7: each received byte occupies exactly one slot
    p_one_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we_vec));

    // R12: a discard leaves no slot marked for programming
    p_discard_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !wr_i) |=> (vld == '0));

endmodule

// File: rtl/twi_ee_array.sv
module twi_ee_array #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (we_i) mem[waddr_i] <= wdata_i;
        rd_q <= mem[raddr_i];
    end

    assign rdata_o = rd_q;

endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave #(
    parameter int ADDR_W      = 13,
    parameter int MEM_AW      = 10,
    parameter int PAGE        = 16,
    parameter int PROG_CYCLES = 5000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] cs_strap_i,
    output logic       sda_pull_o
);
    import twi_ee_pkg::*;

    localparam int SW   = $clog2(PAGE);
    localparam int TW   = $clog2(PROG_CYCLES + 1);
    localparam int HI_W = ADDR_W - 8;

    typedef struct packed {
        twi_st_e          st;
        logic [3:0]       cnt;
        logic [6:0]       sh;
        logic [6:0]       tx;
        logic [ADDR_W-1:0] addr;
        logic             ack;
        logic             mack;
        logic             rw;
        logic             oe;
        logic             have;
        prog_e            pg;
        logic [TW-1:0]    tmr;
        logic [SW-1:0]    cslot;
    } ctl_t;

    localparam ctl_t CTL_RST = '{st: ST_IDLE, pg: PG_OFF, default: '0};

    ctl_t ctl_d, ctl_q;

    logic start, stop, rise, fall;
    logic busy;
    logic [7:0] byte_in;
    logic pb_clr, pb_wr;
    logic [7:0] pb_rdata, mem_rdata;
    logic pb_rvalid;
    logic mem_we;
    logic [MEM_AW-1:0] mem_waddr, mem_raddr;

    twi_bus_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .start_o (start),
        .stop_o  (stop),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    twi_page_buf #(.SLOTS(PAGE), .DW(8)) u_page (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (pb_clr),
        .wr_i     (pb_wr),
        .wslot_i  (ctl_q.addr[SW-1:0]),
        .wdata_i  (byte_in),
        .rslot_i  (ctl_q.cslot),
        .rdata_o  (pb_rdata),
        .rvalid_o (pb_rvalid)
    );

    twi_ee_array #(.AW(MEM_AW), .DW(8)) u_mem (
        .clk     (clk),
        .we_i    (mem_we),
        .waddr_i (mem_waddr),
        .wdata_i (pb_rdata),
        .raddr_i (mem_raddr),
        .rdata_o (mem_rdata)
    );

    assign busy      = (ctl_q.pg != PG_OFF);
    assign byte_in   = {ctl_q.sh, sda_i};
    assign mem_raddr = ctl_q.addr[MEM_AW-1:0];
    assign mem_waddr = MEM_AW'({ctl_q.addr[ADDR_W-1:SW], ctl_q.cslot});

    always_comb begin
        ctl_d  = ctl_q;
        pb_clr = 1'b0;
        pb_wr  = 1'b0;
        mem_we = 1'b0;

        // programming cycle: wait, then copy filled slots one per clock
        case (ctl_q.pg)
            PG_WAIT: begin
                if (ctl_q.tmr == '0) begin
                    ctl_d.pg    = PG_COMMIT;
                    ctl_d.cslot = '0;
                end else begin
                    ctl_d.tmr = ctl_q.tmr - 1'b1;
                end
            end
            PG_COMMIT: begin
                mem_we      = pb_rvalid;
                ctl_d.cslot = ctl_q.cslot + 1'b1;
                if (ctl_q.cslot == SW'(PAGE - 1)) ctl_d.pg = PG_OFF;
            end
            default: ;
        endcase

        if (stop) begin
            ctl_d.st  = ST_IDLE;
            ctl_d.cnt = '0;
            ctl_d.oe  = 1'b0;
            ctl_d.ack = 1'b0;
            if (ctl_q.have && !busy) begin
                ctl_d.pg   = PG_WAIT;
                ctl_d.tmr  = TW'(PROG_CYCLES - 1);
                ctl_d.have = 1'b0;
            end
        end else if (start) begin
            ctl_d.st  = ST_DEV;
            ctl_d.cnt = '0;
            ctl_d.oe  = 1'b0;
            ctl_d.ack = 1'b0;
            if (!busy) begin
                ctl_d.have = 1'b0;
                pb_clr     = 1'b1;
            end
        end else if (ctl_q.st == ST_RDATA) begin
            // slave transmits; master acknowledges in the ninth slot
            if (rise) begin
                if (ctl_q.cnt == 4'd8) begin
                    ctl_d.mack = ~sda_i;
                    if (!sda_i) ctl_d.addr = ctl_q.addr + 1'b1;
                    ctl_d.cnt = 4'd9;
                end else if (ctl_q.cnt < 4'd8) begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end else if (fall) begin
                if (ctl_q.cnt >= 4'd1 && ctl_q.cnt <= 4'd7) begin
                    ctl_d.tx = {ctl_q.tx[5:0], 1'b0};
                    ctl_d.oe = ~ctl_q.tx[6];
                end else if (ctl_q.cnt == 4'd8) begin
                    ctl_d.oe = 1'b0;
                end else if (ctl_q.cnt == 4'd9) begin
                    ctl_d.cnt = '0;
                    if (ctl_q.mack) begin
                        ctl_d.tx = mem_rdata[6:0];
                        ctl_d.oe = ~mem_rdata[7];
                    end else begin
                        ctl_d.st = ST_IDLE;
                        ctl_d.oe = 1'b0;
                    end
                end
            end
        end else if (ctl_q.st != ST_IDLE) begin
            // slave receives select, address and data bytes
            if (rise) begin
                if (ctl_q.cnt < 4'd8) begin
                    ctl_d.sh  = byte_in[6:0];
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                    if (ctl_q.cnt == 4'd7) begin
                        case (ctl_q.st)
                            ST_DEV: begin
                                if (byte_in[7:4] == DEV_TYPE &&
                                    byte_in[3:1] == cs_strap_i && !busy) begin
                                    ctl_d.ack = 1'b1;
                                    ctl_d.rw  = byte_in[0];
                                end else begin
                                    ctl_d.st = ST_SKIP;
                                end
                            end
                            ST_AHI: begin
                                ctl_d.addr[ADDR_W-1:8] = byte_in[HI_W-1:0];
                                ctl_d.ack = 1'b1;
                            end
                            ST_ALO: begin
                                ctl_d.addr[7:0] = byte_in;
                                ctl_d.ack = 1'b1;
                            end
                            ST_WDATA: begin
                                pb_wr = 1'b1;
                                ctl_d.addr[SW-1:0] = ctl_q.addr[SW-1:0] + 1'b1;
                                ctl_d.have = 1'b1;
                                ctl_d.ack  = 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end else if (ctl_q.cnt == 4'd8) begin
                    ctl_d.cnt = 4'd9;
                end
            end else if (fall) begin
                if (ctl_q.cnt == 4'd8) begin
                    ctl_d.oe = ctl_q.ack;
                end else if (ctl_q.cnt == 4'd9) begin
                    ctl_d.oe  = 1'b0;
                    ctl_d.cnt = '0;
                    ctl_d.ack = 1'b0;
                    case (ctl_q.st)
                        ST_DEV: begin
                            if (ctl_q.rw) begin
                                ctl_d.st = ST_RDATA;
                                ctl_d.tx = mem_rdata[6:0];
                                ctl_d.oe = ~mem_rdata[7];
                            end else begin
                                ctl_d.st = ST_AHI;
                            end
                        end
                        ST_AHI:  ctl_d.st = ST_ALO;
                        ST_ALO:  ctl_d.st = ST_WDATA;
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign sda_pull_o = ctl_q.oe;

    // R5: the SDA pull only moves while SCL is low
    p_pull_scl_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull_o != $past(sda_pull_o)) |-> !$past(scl_i));

    // R8: no pull at all while programming
    p_quiet_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_pull_o);

    // R10: a programming cycle begins only with a complete data byte held
    p_prog_needs_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.pg == PG_WAIT && $past(ctl_q.pg) == PG_OFF) |-> $past(ctl_q.have));

    // R3: STOP returns the receiver to idle with SDA released
    p_stop_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (ctl_q.st == ST_IDLE && !sda_pull_o));

    // R2: START re-arms the select byte from bit zero
    p_start_rearm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (ctl_q.st == ST_DEV && ctl_q.cnt == 4'd0));

endmodule

// File: tb/twi_eeprom_slave_tb.sv
module twi_eeprom_slave_tb;

    localparam int PROG = 400;
    localparam int H    = 5;
    localparam logic [2:0] CS = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull;
    logic sda;
    logic [2:0] cs_strap = CS;

    int checks = 0;
    int errors = 0;
    logic [7:0] rbuf [16];

    always #5 clk = ~clk;

    assign sda = sda_m & ~sda_pull;

    twi_eeprom_slave #(.PROG_CYCLES(PROG)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda),
        .cs_strap_i (cs_strap),
        .sda_pull_o (sda_pull)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; step(H);
        scl = 1'b1;   step(H);
        sda_m = 1'b0; step(H);
        scl = 1'b0;   step(2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; step(H);
        scl = 1'b1;   step(H);
        sda_m = 1'b1; step(H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            sda_m = b[7-i]; step(H);
            scl = 1'b1;     step(H);
            scl = 1'b0;     step(2);
        end
    endtask

    // sends a byte and samples the ack slot early and late in its high phase
    task automatic write_byte(input logic [7:0] b, input bit rel_chk,
                              output logic ack);
        logic a1, a2, rel;
        send_bits(b, 8);
        sda_m = 1'b1; step(H);
        scl = 1'b1;   step(1);
        a1 = sda;     step(H - 2);
        a2 = sda;     step(1);
        scl = 1'b0;   step(3);
        rel = sda;
        ack = ~a1;
        if (ack) begin
            chk("R5", a2, 1'b0, "ack held to end of ninth high phase");
            if (rel_chk) chk("R5", rel, 1'b1, "ack released after ninth pulse");
        end
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            sda_m = 1'b1; step(H);
            scl = 1'b1;   step(2);
            b[7-i] = sda; step(H - 2);
            scl = 1'b0;   step(2);
        end
        sda_m = ~give_ack; step(H);
        scl = 1'b1;        step(H);
        scl = 1'b0;        step(2);
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] dev(input logic [2:0] cs, input logic rd);
        return {4'b1010, cs, rd};
    endfunction

    task automatic set_addr(input logic [12:0] a, input string req);
        logic ack;
        bus_start();
        write_byte(dev(CS, 1'b0), 1'b1, ack); chk(req, ack, 1'b1, "select ack");
        write_byte({3'b000, a[12:8]}, 1'b1, ack); chk(req, ack, 1'b1, "addr hi ack");
        write_byte(a[7:0], 1'b1, ack); chk(req, ack, 1'b1, "addr lo ack");
    endtask

    task automatic rd_at(input logic [12:0] a, input int n, input string req);
        logic ack;
        logic [7:0] b;
        set_addr(a, req);
        bus_start();
        write_byte(dev(CS, 1'b1), 1'b0, ack); chk(req, ack, 1'b1, "read select ack");
        for (int i = 0; i < n; i++) begin
            read_byte(i != n - 1, b);
            rbuf[i] = b;
        end
    endtask

    task automatic probe_select(input string req, input logic exp, input string what);
        logic ack;
        bus_start();
        write_byte(dev(CS, 1'b0), 1'b1, ack);
        chk(req, ack, exp, what);
        bus_stop();
    endtask

    task automatic t_reset();
        step(3);
        chk("R1", sda_pull, 1'b0, "pull after reset");
        chk("R1", sda, 1'b1, "bus level after reset");
    endtask

    task automatic t_page_write();
        logic ack;
        logic all_ack = 1'b1;
        set_addr(13'h0120, "R6");
        for (int i = 0; i < 18; i++) begin
            write_byte(8'h40 + 8'(i), 1'b1, ack);
            all_ack &= ack;
        end
        chk("R6", all_ack, 1'b1, "all 18 data bytes acked");
        bus_stop();
        probe_select("R8", 1'b0, "select during programming");
        step(PROG + 60);
        rd_at(13'h0120, 16, "R6");
        step(3);
        chk("R9", sda, 1'b1, "SDA released after master nack");
        chk("R9", sda_pull, 1'b0, "no pull after master nack");
        bus_stop();
        // R7: slots 0 and 1 hold the 17th and 18th bytes
        for (int i = 0; i < 16; i++) begin
            logic [7:0] exp = (i < 2) ? 8'h50 + 8'(i) : 8'h40 + 8'(i);
            chk("R7", rbuf[i], exp, $sformatf("slot %0d after overwrite", i));
        end
    endtask

    task automatic t_mismatch();
        logic ack;
        bus_start();
        write_byte(dev(CS ^ 3'b001, 1'b0), 1'b1, ack);
        chk("R4", ack, 1'b0, "wrong strap select");
        write_byte(8'h00, 1'b1, ack);
        chk("R4", ack, 1'b0, "byte after wrong select");
        bus_stop();
        bus_start();
        write_byte(8'b1011_1010, 1'b1, ack);
        chk("R4", ack, 1'b0, "wrong type nibble");
        bus_stop();
    endtask

    task automatic t_start_abort();
        logic ack;
        bus_start();
        send_bits(8'hA0, 4);
        bus_start();
        write_byte(dev(CS, 1'b0), 1'b1, ack);
        chk("R2", ack, 1'b1, "select after aborting partial byte");
        bus_stop();
    endtask

    task automatic t_stop_ends();
        logic ack;
        bus_start();
        write_byte(dev(CS, 1'b0), 1'b1, ack);
        chk("R3", ack, 1'b1, "select before stop");
        bus_stop();
        scl = 1'b0; step(2);
        write_byte(dev(CS, 1'b0), 1'b1, ack);
        chk("R3", ack, 1'b0, "byte without START after STOP");
        bus_stop();
    endtask

    task automatic t_no_prog();
        set_addr(13'h0120, "R10");
        bus_stop();
        probe_select("R10", 1'b1, "select after address-only write");
        set_addr(13'h0120, "R10");
        send_bits(8'h33, 5);
        bus_stop();
        probe_select("R10", 1'b1, "select after partial data byte");
    endtask

    task automatic t_abort_write();
        logic ack;
        set_addr(13'h0120, "R12");
        write_byte(8'hEE, 1'b1, ack);
        chk("R12", ack, 1'b1, "data byte ack");
        bus_start();
        bus_stop();
        probe_select("R12", 1'b1, "no programming after aborted write");
        rd_at(13'h0120, 1, "R12");
        bus_stop();
        chk("R12", rbuf[0], 8'h50, "memory unchanged by aborted write");
    endtask

    task automatic t_wrap();
        logic ack;
        set_addr(13'h1FFF, "R11");
        write_byte(8'hA1, 1'b1, ack);
        write_byte(8'hA2, 1'b1, ack);
        bus_stop();
        step(PROG + 60);
        set_addr(13'h0000, "R11");
        write_byte(8'hB0, 1'b1, ack);
        bus_stop();
        step(PROG + 60);
        rd_at(13'h1FFF, 2, "R11");
        bus_stop();
        chk("R11", rbuf[0], 8'hA1, "byte at top address");
        chk("R11", rbuf[1], 8'hB0, "address wraps to zero");
        rd_at(13'h1FF0, 1, "R7");
        bus_stop();
        chk("R7", rbuf[0], 8'hA2, "slot index wraps within page");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        step(4);
        rst_n = 1'b1;
        t_reset();
        t_page_write();
        t_mismatch();
        t_start_abort();
        t_stop_ends();
        t_no_prog();
        t_abort_write();
        t_wrap();
        step(10);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule